// File: doc/BRIEF.md
# Transmit Frame Pad and FCS Inserter

This block sits in the transmit byte path between a frame FIFO and an Ethernet transmitter. Frame bytes arrive on a valid/ready interface that carries an end-of-frame flag and two per-frame control bits. The bits are read only from the closing byte of each frame. Every byte is forwarded in order, with no added latency. Once the closing byte has been accepted, the block can stall its input and emit a tail of its own. The tail may be zero pad bytes that bring a short frame up to the Ethernet minimum, a four-byte CRC-32 frame check sequence, or both.

The two control bits are a check-sequence suppress bit and an auto-pad bit. Auto-pad takes priority over the suppress bit: a padded frame always carries a check sequence. The check sequence covers every byte that leaves the block before it, including any pad bytes. Preamble, collisions, retries and the line interface belong to later stages.

Top module: `frame_pad_fcs`

## Requirements
- R1: The control bits `in_nofcs` and `in_autopad` are used only on the byte accepted with `in_eof`=1. Their values on any other byte have no effect on the output.
- R2: When the closing byte has `in_nofcs`=0, four check-sequence bytes follow the frame data and any pad.
- R3: When the closing byte has `in_nofcs`=1 and `in_autopad`=0, no bytes follow the data, and `out_last` is high on the closing data byte.
- R4: When the closing byte has `in_autopad`=1, the check sequence is appended whatever the value of `in_nofcs`.
- R5: With auto-pad, a frame of fewer than 60 data bytes is followed by bytes of value 0x00 until 60 bytes have been sent. The check sequence then brings the total to 64.
- R6: With auto-pad, a frame of 60 or more data bytes gets no pad bytes.
- R7: The check sequence is the CRC-32 with reflected polynomial 0xEDB88320, seed 0xFFFFFFFF and a final inversion. It is computed over the data and pad bytes and sent least significant byte first. For the nine ASCII bytes "123456789" the four bytes are 0x26, 0x39, 0xF4, 0xCB.
- R8: Data bytes leave in order and unchanged. `out_last` is high only on the final byte of each frame. `in_ready` is low while pad or check-sequence bytes are being sent. A stalled output holds its byte and its flag.
- R9: After reset the block is at a frame boundary: `out_valid` is low until an input byte is offered, and the next byte starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes the input byte this cycle |
| in_data | input | 8 | Input frame byte |
| in_eof | input | 1 | Byte is the last data byte of its frame |
| in_nofcs | input | 1 | Suppress check sequence (read with the EOF byte) |
| in_autopad | input | 1 | Pad to minimum and force check sequence (read with the EOF byte) |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |

## Verification
The assertions assume that the source follows the valid/ready rule. Once a byte is offered, its data, end flag and both control bits stay fixed until it is accepted. The hold-under-stall and last-flag properties depend on this. The bench driver keeps every input constant from the cycle it raises `in_valid` until it sees `in_ready`, while a separate process randomises `out_ready` to force stalls inside data, pad and check-sequence phases. The driver also randomises the control bits on bytes that are not the closing byte, so that any leak from those bytes shows up in the tails the scoreboard expects.

// File: rtl/fpf_pkg.sv
package fpf_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } fpf_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // Advance a reflected CRC-32 by one byte, bit 0 of the byte first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r >> 1) ^ (CRC_POLY & {32{r[0] ^ d[i]}});
    end
    return r;
  endfunction

endpackage

// File: rtl/fpf_crc.sv
module fpf_crc
  import fpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [DATA_W-1:0] data,
  output logic [31:0]       crc_q
);

  logic [31:0] crc_d;
  logic        crc_en;

  always_comb begin
    crc_en = clr | upd;
    if (clr) crc_d = CRC_SEED;
    else     crc_d = crc_step(crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_d;
  end

endmodule

// File: rtl/fpf_len.sv
module fpf_len #(
  parameter int LIMIT = 60,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != CNT_MAX));
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fpf_seq.sv
module fpf_seq
  import fpf_pkg::*;
#(
  parameter int FCS_BYTES = 4,
  localparam int IDX_W = $clog2(FCS_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof_fire,
  input  logic             want_pad,
  input  logic             want_fcs,
  input  logic             out_fire,
  input  logic             pad_end,
  output fpf_state_e       st_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             fcs_end
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

  fpf_state_e       st_d;
  logic [IDX_W-1:0] idx_d;
  logic             st_en;
  logic             idx_en;

  always_comb begin
    fcs_end = (idx_q == IDX_LAST);
    st_d    = st_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (st_q)
      ST_DATA: begin
        if (eof_fire) begin
          if (want_pad)      st_d = ST_PAD;
          else if (want_fcs) st_d = ST_FCS;
        end
      end
      ST_PAD: begin
        if (out_fire && pad_end) st_d = ST_FCS;
      end
      ST_FCS: begin
        if (out_fire) begin
          idx_en = 1'b1;
          if (fcs_end) begin
            idx_d = '0;
            st_d  = ST_DATA;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_DATA;
    endcase
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_DATA;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

endmodule

// File: rtl/frame_pad_fcs.sv
module frame_pad_fcs
  import fpf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MIN_LEN   = 64,
  parameter int FCS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic              in_nofcs,
  input  logic              in_autopad,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);

  localparam int PAD_TARGET = MIN_LEN - FCS_BYTES;
  localparam int CNT_W      = $clog2(PAD_TARGET + 1);
  localparam int IDX_W      = $clog2(FCS_BYTES);
  localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(PAD_TARGET - 1);

  fpf_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             fcs_end;
  logic [CNT_W-1:0] len_q;
  logic [31:0]      crc_q;
  logic [31:0]      fcs_word;

  logic in_fire, out_fire, eof_fire, frame_end;
  logic want_fcs, want_pad, pad_end, crc_upd;

  // Tail decisions come from the closing byte's control bits alone.
  always_comb begin
    want_fcs = in_autopad | ~in_nofcs;
    want_pad = in_autopad & (len_q < PAD_LAST);
    pad_end  = (len_q == PAD_LAST);
    fcs_word = ~crc_q;
  end

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    unique case (st_q)
      ST_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_eof & ~want_fcs;
      end
      ST_PAD: begin
        out_valid = 1'b1;
        out_data  = '0;
      end
      ST_FCS: begin
        out_valid = 1'b1;
        out_data  = DATA_W'(fcs_word >> {idx_q, 3'b000});
        out_last  = fcs_end;
      end
      default: begin
        out_valid = 1'b0;
      end
    endcase
  end

  always_comb begin
    in_fire   = in_valid & in_ready;
    out_fire  = out_valid & out_ready;
    eof_fire  = in_fire & in_eof;
    frame_end = out_fire & out_last;
    crc_upd   = out_fire & (st_q != ST_FCS);
  end

  fpf_seq #(.FCS_BYTES(FCS_BYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .eof_fire (eof_fire),
    .want_pad (want_pad),
    .want_fcs (want_fcs),
    .out_fire (out_fire),
    .pad_end  (pad_end),
    .st_q     (st_q),
    .idx_q    (idx_q),
    .fcs_end  (fcs_end)
  );

  fpf_len #(.LIMIT(PAD_TARGET)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_end),
    .inc   (out_fire),
    .cnt_q (len_q)
  );

  fpf_crc #(.DATA_W(DATA_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_end),
    .upd   (crc_upd),
    .data  (out_data),
    .crc_q (crc_q)
  );

endmodule

// File: rtl/fpf_chk.sv
module fpf_chk #(
  parameter int DATA_W    = 8,
  parameter int MIN_LEN   = 64,
  parameter int FCS_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_eof,
  input logic              in_nofcs,
  input logic              in_autopad,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last
);

  localparam int PAD_TARGET = MIN_LEN - FCS_BYTES;

  logic [15:0] cnt_q;
  logic        tail_q;
  logic        ap_q;
  logic        ofire, ifire;

  always_comb begin
    ofire = out_valid & out_ready;
    ifire = in_valid & in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tail_q <= 1'b0;
      ap_q   <= 1'b0;
    end else begin
      if (ofire && out_last)        cnt_q <= '0;
      else if (ofire && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
      if (ofire && out_last)        tail_q <= 1'b0;
      else if (ifire && in_eof)     tail_q <= 1'b1;
      if (ifire && in_eof)          ap_q <= in_autopad;
    end
  end

  // R3: suppressed sequence without auto-pad ends the frame on the data byte
  a_r3_last_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (ifire && in_eof && in_nofcs && !in_autopad) |-> out_last);

  // R2: a frame owed a check sequence does not end on its data byte
  a_r2_tail_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ifire && in_eof && !(in_nofcs && !in_autopad)) |-> !out_last);

  // R5: bytes after the data and below the pad target are zero
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q && ap_q && out_valid && (cnt_q < 16'(PAD_TARGET))) |-> (out_data == '0));

  // R5: padded frames reach the minimum length
  a_r5_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ofire && out_last && tail_q && ap_q) |-> (cnt_q >= 16'(MIN_LEN - 1)));

  // R8: input is held off while the tail is sent
  a_r8_tail_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q |-> !in_ready);

  // R8: a stalled output byte holds
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind frame_pad_fcs fpf_chk u_chk (.*);

// File: tb/tb_frame_pad_fcs.sv
module tb_frame_pad_fcs;

  logic       clk;
  logic       rst_n;
  logic       in_valid, in_ready, in_eof, in_nofcs, in_autopad;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit rdy_rand = 0;
  bit done = 0;

  logic [7:0] exp_d[$];
  logic       exp_l[$];
  string      exp_t[$];

  frame_pad_fcs dut (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rdy_rand) out_ready = (($urandom % 4) != 0);
    else          out_ready = 1'b1;
  end

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[k]) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ b[k][i];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare each transferred output byte with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          check("R8 unexpected byte", 1, 0);
        end else begin
          logic [7:0] d;
          logic       l;
          string      t;
          d = exp_d.pop_front();
          l = exp_l.pop_front();
          t = exp_t.pop_front();
          check({t, " data"}, out_data, d);
          check({t, " R8 last"}, out_last, l);
        end
      end
    end
  end

  task automatic put_byte(input logic [7:0] d, input logic eof, input logic nf, input logic ap);
    bit ok;
    in_valid = 1; in_data = d; in_eof = eof; in_nofcs = nf; in_autopad = ap;
    ok = 0;
    while (!ok) begin
      #4;
      ok = in_ready;
      @(negedge clk);
    end
    in_valid = 0; in_eof = 0;
  endtask

  task automatic send_frame(input logic [7:0] fr[$], input logic nf, input logic ap,
                            input string tag, input bit scramble);
    logic [7:0] all[$];
    logic       fcs;
    logic [31:0] c;
    all = fr;
    fcs = ap | ~nf;
    foreach (fr[k]) begin
      exp_d.push_back(fr[k]);
      exp_l.push_back(!fcs && (k == fr.size() - 1));
      exp_t.push_back({tag, " R8"});
    end
    if (ap) begin
      while (all.size() < 60) begin
        all.push_back(8'h00);
        exp_d.push_back(8'h00); exp_l.push_back(1'b0); exp_t.push_back({tag, " R5 pad"});
      end
    end
    if (fcs) begin
      c = ref_crc(all);
      for (int i = 0; i < 4; i++) begin
        exp_d.push_back(c[8*i +: 8]); exp_l.push_back(i == 3); exp_t.push_back({tag, " R7 fcs"});
      end
    end
    foreach (fr[k]) begin
      if (k == fr.size() - 1) put_byte(fr[k], 1'b1, nf, ap);
      else if (scramble)      put_byte(fr[k], 1'b0, 1'($urandom), 1'($urandom));
      else                    put_byte(fr[k], 1'b0, nf, ap);
    end
  endtask

  function automatic void mk(ref logic [7:0] q[$], input int n);
    q.delete();
    for (int i = 0; i < n; i++) q.push_back(8'($urandom));
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] f[$];
    in_valid = 0; in_data = 0; in_eof = 0; in_nofcs = 0; in_autopad = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #4;
    check("R9 out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #4;
    check("R9 out_valid idle after reset", out_valid, 0);
    @(negedge clk);

    // Known vector, check sequence only
    f = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    exp_d.push_back(0); exp_d.pop_back();
    send_frame(f, 1'b0, 1'b0, "R2/R7 vector", 0);
    while (exp_d.size() != 0) @(negedge clk);
    check("R7 vector fcs byte count", exp_d.size(), 0);

    mk(f, 10); send_frame(f, 1'b1, 1'b0, "R3 nofcs", 0);
    mk(f, 20); send_frame(f, 1'b1, 1'b1, "R4 ap over nofcs", 0);
    mk(f, 1);  send_frame(f, 1'b0, 1'b1, "R5 one byte", 0);
    mk(f, 59); send_frame(f, 1'b0, 1'b1, "R5 len59", 0);
    mk(f, 60); send_frame(f, 1'b1, 1'b1, "R6 len60", 0);
    mk(f, 61); send_frame(f, 1'b0, 1'b1, "R6 len61", 0);
    mk(f, 70); send_frame(f, 1'b0, 1'b0, "R2 len70", 0);

    rdy_rand = 1;
    for (int n = 0; n < 24; n++) begin
      logic nf, ap;
      nf = 1'($urandom); ap = 1'($urandom);
      mk(f, 1 + ($urandom % 80));
      send_frame(f, nf, ap, "R1 scrambled", 1);
    end
    mk(f, 5);  send_frame(f, 1'b1, 1'b0, "R1 nofcs scrambled", 1);
    mk(f, 30); send_frame(f, 1'b0, 1'b1, "R1 pad scrambled", 1);

    while (exp_d.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", exp_d.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule